// File: doc/BRIEF.md
# Block Transfer and Search Sequencer

This block executes the memory-to-memory copy and the memory search instructions of an 8-bit processor core. When its start pulse arrives, it takes the selected operation code, the accumulator, the three 16-bit working registers (source pointer, destination pointer and byte counter) and the current flag byte. It then steps through memory over a simple request/ready port. Each step reads one byte at the source pointer. A copy step writes that byte at the destination pointer. A search step compares the byte against the accumulator and writes nothing.

Each operation comes in a single-step form and a repeating form, and either walks upward or downward through memory. When the work is finished, the block raises a one-cycle done pulse. At that point it presents the updated registers, the updated flag byte and the elapsed instruction cycle count, so the surrounding core can charge the time to its own timing model. Instruction fetch, decode and interrupt acceptance between iterations stay with the core.

Top module: `blkmove_seq`

## Requirements
- R1: A start pulse while idle begins an operation only for the codes 0xA0, 0xA8, 0xB0, 0xB8, 0xA1, 0xA9, 0xB1 and 0xB9. In these codes, bit 0 selects search (1) or copy (0), bit 3 selects downward (1) or upward (0), and bit 4 selects repeating (1) or single (0). Any other code leaves the block idle, with no memory request and no done pulse.
- R2: A copy step reads the byte at the source pointer and writes it at the destination pointer. It then moves both pointers by one in the selected direction and decrements the counter.
- R3: A search step reads the byte at the source pointer and issues no write. It moves the source pointer by one in the selected direction, decrements the counter and leaves the destination pointer unchanged.
- R4: A repeating copy keeps stepping until the counter reaches 0.
- R5: A repeating search stops after the step whose byte equals the accumulator, or after the step that brings the counter to 0, whichever comes first.
- R6: After every step, flag bit 2 is 1 when the counter is non-zero and 0 when it is 0.
- R7: A search step sets flag bit 7 to bit 7 of the accumulator minus the byte, sets bit 6 when they are equal, sets bit 4 on a borrow out of the low nibble, and sets bit 1. A copy step clears bits 4 and 1 and keeps bits 7 and 6. Bits 0, 3 and 5 always keep their input value.
- R8: A starting counter of 0 counts as 65536 steps: the first step leaves 0xFFFF.
- R9: The reported cycle count adds 21 for every step that is followed by another step and 16 for the final step.
- R10: Each step makes exactly one read and, for a copy, one write after it. Each request holds its address, direction and write data until the cycle in which ready is sampled high.
- R11: Busy is high from the cycle after an accepted start until the done pulse. Done lasts exactly one cycle. A start pulse arriving while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| op | input | 8 | Operation code, see R1 |
| acc | input | 8 | Accumulator value used by searches |
| hl_in | input | 16 | Initial source pointer |
| de_in | input | 16 | Initial destination pointer |
| bc_in | input | 16 | Initial byte counter |
| flags_in | input | 8 | Flag byte before the operation |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| hl_out | output | 16 | Updated source pointer |
| de_out | output | 16 | Updated destination pointer |
| bc_out | output | 16 | Updated byte counter |
| flags_out | output | 8 | Updated flag byte |
| cycles_out | output | 32 | Elapsed instruction cycles of the last operation |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 16 | Request address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with ready |
| mem_ready | input | 1 | Request completes in this cycle |

## Verification
The assertions check, on every cycle, the properties that hold in any single step. Requests stay steady while ready is low. Searches never write. Done is a lone pulse with busy low. At done, bit 2 agrees with the counter and the carry matches the value captured at start. A repeating copy always ends with a zero counter. The cycle total is always 16 plus a multiple of 21. The bench alone can show that the address and data sequences match a step-by-step model. It also covers the search stopping on the exact matching byte, the counter wrapping from 0, the exact flag values, rejected codes, and a start pulse injected mid-operation.

// File: rtl/blkmove_seq.sv
module blkmove_seq #(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int CW        = 32,
  parameter int REP_COST  = 21,
  parameter int LAST_COST = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [7:0]    op,
  input  logic [DW-1:0] acc,
  input  logic [AW-1:0] hl_in,
  input  logic [AW-1:0] de_in,
  input  logic [AW-1:0] bc_in,
  input  logic [7:0]    flags_in,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] hl_out,
  output logic [AW-1:0] de_out,
  output logic [AW-1:0] bc_out,
  output logic [7:0]    flags_out,
  output logic [CW-1:0] cycles_out,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready
);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_STEP} st_t;

  st_t           st;
  logic          is_cmp, is_dec, is_rep;
  logic [DW-1:0] acc_q, byte_q;
  logic [AW-1:0] hl_q, de_q, bc_q;
  logic [7:0]    f_q, f_nx;
  logic [CW-1:0] cyc_q;

  wire           op_ok  = (op[7:5] == 3'b101) && (op[2:1] == 2'b00);
  wire [AW-1:0]  bc_nx  = bc_q - AW'(1);
  wire [AW-1:0]  delta  = is_dec ? {AW{1'b1}} : AW'(1);
  wire [DW-1:0]  diff   = acc_q - byte_q;
  wire           match  = is_cmp && (diff == '0);
  wire           again  = is_rep && (bc_nx != '0) && !match;

  always_comb begin
    f_nx    = f_q;
    f_nx[2] = (bc_nx != '0);
    if (is_cmp) begin
      f_nx[7] = diff[DW-1];
      f_nx[6] = (diff == '0);
      f_nx[4] = (acc_q[3:0] < byte_q[3:0]);
      f_nx[1] = 1'b1;
    end else begin
      f_nx[4] = 1'b0;
      f_nx[1] = 1'b0;
    end
  end

  assign busy       = (st != S_IDLE);
  assign mem_req    = (st == S_RD) || (st == S_WR);
  assign mem_we     = (st == S_WR);
  assign mem_addr   = (st == S_WR) ? de_q : hl_q;
  assign mem_wdata  = byte_q;
  assign hl_out     = hl_q;
  assign de_out     = de_q;
  assign bc_out     = bc_q;
  assign flags_out  = f_q;
  assign cycles_out = cyc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      done   <= 1'b0;
      is_cmp <= 1'b0;
      is_dec <= 1'b0;
      is_rep <= 1'b0;
      acc_q  <= '0;
      byte_q <= '0;
      hl_q   <= '0;
      de_q   <= '0;
      bc_q   <= '0;
      f_q    <= '0;
      cyc_q  <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start && op_ok) begin
          is_cmp <= op[0];
          is_dec <= op[3];
          is_rep <= op[4];
          acc_q  <= acc;
          hl_q   <= hl_in;
          de_q   <= de_in;
          bc_q   <= bc_in;
          f_q    <= flags_in;
          cyc_q  <= '0;
          st     <= S_RD;
        end
        S_RD: if (mem_ready) begin
          byte_q <= mem_rdata;
          st     <= is_cmp ? S_STEP : S_WR;
        end
        S_WR: if (mem_ready) st <= S_STEP;
        default: begin
          hl_q <= hl_q + delta;
          if (!is_cmp) de_q <= de_q + delta;
          bc_q <= bc_nx;
          f_q  <= f_nx;
          if (again) begin
            cyc_q <= cyc_q + CW'(REP_COST);
            st    <= S_RD;
          end else begin
            cyc_q <= cyc_q + CW'(LAST_COST);
            done  <= 1'b1;
            st    <= S_IDLE;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/blkmove_seq_chk.sv
module blkmove_seq_chk #(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int CW        = 32,
  parameter int REP_COST  = 21,
  parameter int LAST_COST = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [7:0]    op,
  input logic          op_ok,
  input logic          is_cmp,
  input logic [7:0]    flags_in,
  input logic          busy,
  input logic          done,
  input logic [AW-1:0] bc_out,
  input logic [7:0]    flags_out,
  input logic [CW-1:0] cycles_out,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_ready
);

  logic       c_keep;
  logic [7:0] op_lat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_keep <= 1'b0;
      op_lat <= 8'h00;
    end else if (start && !busy && op_ok) begin
      c_keep <= flags_in[0];
      op_lat <= op;
    end
  end

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R10
  req_in_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  // R3
  search_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && is_cmp |-> !mem_we);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R1
  bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && !op_ok |=> !busy);

  // R6
  pv_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> flags_out[2] == (bc_out != '0));

  // R7
  carry_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> flags_out[0] == c_keep);

  // R4
  copy_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && (op_lat == 8'hB0 || op_lat == 8'hB8) |-> bc_out == '0);

  // R9
  cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cycles_out >= CW'(LAST_COST) && ((cycles_out - CW'(LAST_COST)) % CW'(REP_COST)) == '0);

endmodule

bind blkmove_seq blkmove_seq_chk #(
  .AW(AW), .DW(DW), .CW(CW), .REP_COST(REP_COST), .LAST_COST(LAST_COST)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .op(op), .op_ok(op_ok),
  .is_cmp(is_cmp), .flags_in(flags_in), .busy(busy), .done(done),
  .bc_out(bc_out), .flags_out(flags_out), .cycles_out(cycles_out),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ready(mem_ready)
);

// File: tb/blkmove_seq_bench.sv
`timescale 1ns/1ps
module blkmove_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  op_i = 8'h00, acc_i = 8'h00, flags_i = 8'h00;
  logic [15:0] hl_i = '0, de_i = '0, bc_i = '0;
  logic        busy, done, mem_req, mem_we;
  logic [15:0] hl_o, de_o, bc_o, mem_addr;
  logic [7:0]  flags_o, mem_wdata;
  logic [7:0]  mem_rdata = 8'h00;
  logic        mem_ready = 1'b0;
  logic [31:0] cyc_o;

  always #10 clk = ~clk;

  blkmove_seq u_blkmove_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op_i), .acc(acc_i),
    .hl_in(hl_i), .de_in(de_i), .bc_in(bc_i), .flags_in(flags_i),
    .busy(busy), .done(done), .hl_out(hl_o), .de_out(de_o), .bc_out(bc_o),
    .flags_out(flags_o), .cycles_out(cyc_o), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready)
  );

  int n_chk = 0, n_fail = 0, clk_cnt = 0, lat = 0, wait_cnt = 0;
  logic [7:0]  mem [256];
  logic [7:0]  ref_mem [256];
  logic [24:0] xq [$];
  logic [15:0] e_hl, e_de, e_bc;
  logic [7:0]  e_f;
  int          e_cyc;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    clk_cnt++;
    if (clk_cnt > 190000) begin
      n_fail++;
      $display("FAIL R11 watchdog expired: got %0d expected <190000", clk_cnt);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // transaction monitor, compared on every handshake clock
  always @(posedge clk) begin
    if (rst_n && mem_req && mem_ready) begin
      if (xq.size() == 0) begin
        chk(1'b0, "R10", "unexpected request", {15'd0, mem_we, mem_addr}, 32'h0);
      end else begin
        logic [24:0] e;
        e = xq.pop_front();
        chk(mem_we == e[24] && mem_addr == e[23:8] && (!mem_we || mem_wdata == e[7:0]),
            e[24] ? "R2" : "R10", "transaction",
            {7'd0, mem_we, mem_addr, mem_wdata}, {7'd0, e});
      end
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    end
  end

  // memory responder with programmable latency
  always @(negedge clk) begin
    if (mem_ready) begin
      mem_ready <= 1'b0;
      wait_cnt  <= 0;
    end else if (mem_req) begin
      if (wait_cnt >= lat) begin
        mem_ready <= 1'b1;
        mem_rdata <= mem[mem_addr[7:0]];
      end else begin
        wait_cnt <= wait_cnt + 1;
      end
    end
  end

  task automatic model_op(input logic [7:0] op, input logic [7:0] a,
                          input logic [15:0] hl, input logic [15:0] de,
                          input logic [15:0] bc, input logic [7:0] f);
    bit more;
    logic [7:0] m, d;
    logic [15:0] stp;
    stp = op[3] ? 16'hFFFF : 16'h0001;
    e_cyc = 0;
    do begin
      m = ref_mem[hl[7:0]];
      xq.push_back({1'b0, hl, 8'h00});
      if (!op[0]) begin
        xq.push_back({1'b1, de, m});
        ref_mem[de[7:0]] = m;
        de = de + stp;
        f[4] = 1'b0;
        f[1] = 1'b0;
      end else begin
        d = a - m;
        f[7] = d[7];
        f[6] = (d == 8'h00);
        f[4] = (a[3:0] < m[3:0]);
        f[1] = 1'b1;
      end
      hl = hl + stp;
      bc = bc - 16'd1;
      f[2] = (bc != 16'd0);
      more = op[4] && (bc != 16'd0) && !(op[0] && a == m);
      e_cyc += more ? 21 : 16;
    end while (more);
    e_hl = hl; e_de = de; e_bc = bc; e_f = f;
  endtask

  task automatic run(input logic [7:0] op, input logic [7:0] a,
                     input logic [15:0] hl, input logic [15:0] de,
                     input logic [15:0] bc, input logic [7:0] f,
                     input bit inject, input string tag);
    int n, bad;
    model_op(op, a, hl, de, bc, f);
    @(negedge clk);
    op_i = op; acc_i = a; hl_i = hl; de_i = de; bc_i = bc; flags_i = f;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R11", {tag, " busy after start"}, busy, 1);
    n = 0;
    while (!done && n < 20000) begin
      if (inject && n == 4) begin
        start = 1'b1; op_i = 8'hB8; hl_i = 16'h0077; bc_i = 16'h0003;
      end else start = 1'b0;
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    chk(done == 1'b1, "R11", {tag, " done seen"}, done, 1);
    chk(hl_o == e_hl, tag, "source pointer", hl_o, e_hl);
    chk(de_o == e_de, tag, "destination pointer", de_o, e_de);
    chk(bc_o == e_bc, tag, "counter", bc_o, e_bc);
    chk(flags_o == e_f, "R7", {tag, " flags"}, flags_o, e_f);
    chk(flags_o[2] == (e_bc != 0), "R6", {tag, " bit 2"}, flags_o[2], e_bc != 0);
    chk(cyc_o == e_cyc, "R9", {tag, " cycles"}, cyc_o, e_cyc);
    chk(xq.size() == 0, "R10", {tag, " pending transactions"}, xq.size(), 0);
    bad = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== ref_mem[i]) bad++;
    chk(bad == 0, "R2", {tag, " memory image"}, bad, 0);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R11", {tag, " done one cycle"}, {done, busy}, 0);
    xq.delete();
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 7 + 3);
      ref_mem[i] = 8'(i * 7 + 3);
    end
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && mem_req == 0, "R11", "reset state",
        {busy, done, mem_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 single copy up, keeps S/Z, clears H/N, keeps carry and bits 5,3
    lat = 0;
    run(8'hA0, 8'h00, 16'h0010, 16'h0080, 16'h0005, 8'hFB, 0, "R2");
    // R2 single copy down reaching zero
    lat = 2;
    run(8'hA8, 8'h00, 16'h0015, 16'h0090, 16'h0001, 8'h29, 0, "R2");
    // R4 repeating copy up
    lat = 1;
    run(8'hB0, 8'h00, 16'h0018, 16'h00A0, 16'h0006, 8'h01, 0, "R4");
    // R4 repeating copy down, stray start while busy (R11)
    lat = 3;
    run(8'hB8, 8'h00, 16'h001F, 16'h00BF, 16'h0004, 8'hC0, 1, "R4");
    // R3 single search up with a match
    lat = 0;
    run(8'hA1, ref_mem[8'h44], 16'h0044, 16'h1234, 16'h0009, 8'h28, 0, "R3");
    // R3 single search down without a match
    lat = 2;
    run(8'hA9, 8'h10, 16'h0050, 16'h4321, 16'h0002, 8'h01, 0, "R3");
    // R5 repeating search up stopping on third byte
    lat = 1;
    run(8'hB1, ref_mem[8'h42], 16'h0040, 16'h0000, 16'h000A, 8'h00, 0, "R5");
    // R5 repeating search down exhausting the counter
    lat = 0;
    run(8'hB9, 8'h01, 16'h0058, 16'h0000, 16'h0004, 8'h29, 0, "R5");
    // R8 zero counter wraps through 0xFFFF
    lat = 1;
    run(8'hB1, ref_mem[8'h31], 16'h0030, 16'h0000, 16'h0000, 8'h00, 0, "R8");
    lat = 0;
    run(8'hA0, 8'h00, 16'h0011, 16'h00C0, 16'h0000, 8'h00, 0, "R8");

    // R1 rejected code
    @(negedge clk);
    op_i = 8'hA2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    begin
      int seen;
      seen = 0;
      for (int k = 0; k < 6; k++) begin
        if (busy || mem_req || done) seen++;
        @(negedge clk);
      end
      chk(seen == 0, "R1", "code 0xA2 ignored", seen, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule